// File: doc/BRIEF.md
# Timer Trigger Output Source Selector

This block is an up-counting timer that drives a single synchronisation output, `trgo`, which a second timer can follow. It holds a prescaler, a counter with an auto-reload limit, and four compare channels. Each channel makes a reference level that is high while the count is at or above its compare value. A 3-bit master mode field picks one of eight internal sources to drive `trgo`: a software update strobe, the counter enable, the update event, a channel-1 match pulse, or one of the four compare references.

The counter can run from a software enable bit or take part in a simple slave arrangement. In gated mode the external trigger input enables counting. In restart mode a rising trigger edge clears the count. The trigger path adds one clock before `trgo` shows its effect. A sync bit can delay the counter's reaction by the same clock so that the local count and `trgo` move together. The output is registered, and the mode field takes effect at the next clock edge.

Top module: `trig_out_sel`

## Requirements
- R1: While `rstN` is low, `cntOut` and `trgo` are 0.
- R2: With the counter enabled, the prescaler passes one count every `pscDiv`+1 clocks. The counter steps from 0 up to `reloadVal`, then returns to 0 on the next step.
- R3: A high `ugStrobe` at a clock edge clears both the counter and the prescaler at that edge. The strobe takes priority over counting.
- R4: Master mode 3'b010 puts the update event on `trgo`. The update event is the counter stepping from `reloadVal` to 0, or `ugStrobe`. `trgo` is high for exactly the clock cycle in which the count first shows 0.
- R5: Master mode 3'b000 puts a one-cycle pulse on `trgo` in the cycle after `ugStrobe` is sampled. In restart slave mode it also pulses for a trigger rising edge. Without sync, this pulse comes one cycle after the counter clears. With `msmSync` high, the counter clear is held back one clock and the clear and the pulse show in the same cycle.
- R6: `slaveMode` is encoded as follows. 2'b00 (and 2'b11) is free running: `cntEnBit` enables counting. 2'b01 is gated: `trigIn` enables counting and `cntEnBit` is ignored. 2'b10 is restart: `cntEnBit` enables counting, and a rising edge of `trigIn` clears the counter and the prescaler.
- R7: Master mode 3'b001 puts the counter enable level on `trgo`. When the enable comes from `cntEnBit`, `trgo` changes in the same cycle as the count. When the enable comes from `trigIn` in gated mode, `trgo` lags the count by one cycle unless `msmSync` is high. With `msmSync` high, the count reacts one cycle later and lines up with `trgo`.
- R8: Master mode 3'b011 gives a one-cycle `trgo` pulse in each cycle where the count has just stepped onto the channel-1 compare value. This includes a wrap onto 0 and repeats every period. A clear by `ugStrobe` is not a match.
- R9: Master modes 3'b100, 3'b101, 3'b110 and 3'b111 put the reference of channel 1, 2, 3 and 4 on `trgo`. Channel n compares against bits [8n-1:8(n-1)] of `cmpVals` (default width). `trgo` equals the previous cycle's value of (count >= compare value).
- R10: `trgo` is registered. A change of `masterMode` shows on `trgo` after the next clock edge.
- R11: When `ugStrobe` and a natural wrap fall at the same edge, the count goes to 0, `trgo` in mode 3'b010 gives one single-cycle pulse, and counting resumes from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ugStrobe | input | 1 | Software update-generate strobe |
| cntEnBit | input | 1 | Software counter enable |
| trigIn | input | 1 | External trigger input, already synchronous |
| slaveMode | input | 2 | Slave behaviour: free, gated, restart |
| msmSync | input | 1 | Delay trigger effect on the counter by one clock |
| masterMode | input | 3 | Selects the source of `trgo` |
| pscDiv | input | PSC_W | Prescaler divide value minus one |
| reloadVal | input | CNT_W | Auto-reload (top) count value |
| cmpVals | input | 4*CNT_W | Compare values, channel 1 in the low bits |
| cntOut | output | CNT_W | Current count |
| trgo | output | 1 | Registered trigger output |

## Verification
The closest collision is a software update strobe that lands on the same edge as a natural wrap from the reload value. Both would raise the update event and clear the count. The bench provokes this by running a short period and pulsing the strobe exactly on the wrap edge. It then expects a count of 0, a single-cycle pulse on the update-selected output, and a count of 1 one cycle later. A second collision is a trigger edge against ordinary counting in restart mode. There the bench checks, per cycle, that the clear wins and that the output pulse lands one cycle after the clear, or on the clear itself when sync is set.

// File: rtl/trig_out_pkg.sv
package trig_out_pkg;

  localparam int NUM_REF = 4;

  typedef enum logic [1:0] {
    SLV_FREE    = 2'b00,
    SLV_GATED   = 2'b01,
    SLV_RESTART = 2'b10,
    SLV_SPARE   = 2'b11
  } slave_mode_e;

  typedef enum logic [2:0] {
    MM_SWRESET = 3'b000,
    MM_ENABLE  = 3'b001,
    MM_UPDATE  = 3'b010,
    MM_CC1PUL  = 3'b011,
    MM_REF1    = 3'b100,
    MM_REF2    = 3'b101,
    MM_REF3    = 3'b110,
    MM_REF4    = 3'b111
  } master_mode_e;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic run;       // counting allowed this cycle
    logic clear;     // clear counter and prescaler
    logic swUpdate;  // software update request
  } cnt_ctrl_t;

  // trigger-side sources handed to the output selector
  typedef struct packed {
    logic enLevel;   // counter enable as seen on the trigger output
    logic resetMark; // pulse for mode 000
  } trg_src_t;

endpackage

// File: rtl/trig_out_ctrl.sv
module trig_out_ctrl
  import trig_out_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ugStrobe,
  input  logic       cntEnBit,
  input  logic       trigIn,
  input  logic [1:0] slaveMode,
  input  logic       msmSync,
  output cnt_ctrl_t  cntCtl,
  output trg_src_t   trgSrc
);

  logic trigQ, trigQ2;
  slave_mode_e sm;
  logic trigLive, riseLive, riseLate;
  logic runSel, restartSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigQ  <= 1'b0;
      trigQ2 <= 1'b0;
    end else begin
      trigQ  <= trigIn;
      trigQ2 <= trigQ;
    end
  end

  assign sm       = slave_mode_e'(slaveMode);
  // one-clock-late view of the trigger, used for the output path always
  assign riseLate = trigQ & ~trigQ2;
  // counter view: immediate, or held back to line up with the output
  assign trigLive = msmSync ? trigQ : trigIn;
  assign riseLive = msmSync ? riseLate : (trigIn & ~trigQ);

  always_comb begin
    runSel     = cntEnBit;
    restartSel = 1'b0;
    unique case (sm)
      SLV_GATED:   runSel     = trigLive;
      SLV_RESTART: restartSel = riseLive;
      default:     ;
    endcase
  end

  always_comb begin
    cntCtl.run      = runSel;
    cntCtl.clear    = ugStrobe | restartSel;
    cntCtl.swUpdate = ugStrobe;
    trgSrc.enLevel   = (sm == SLV_GATED) ? trigQ : cntEnBit;
    trgSrc.resetMark = ugStrobe | ((sm == SLV_RESTART) & riseLate);
  end

endmodule

// File: rtl/trig_out_datapath.sv
module trig_out_datapath
  import trig_out_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PSC_W = 8,
  localparam int CMP_W = NUM_REF * CNT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  cnt_ctrl_t          cntCtl,
  input  logic [PSC_W-1:0]   pscDiv,
  input  logic [CNT_W-1:0]   reloadVal,
  input  logic [CMP_W-1:0]   cmpVals,
  output logic [CNT_W-1:0]   cnt,
  output logic               updEvt,
  output logic               cc1Evt,
  output logic [NUM_REF-1:0] ocRef
);

  logic [PSC_W-1:0] pscCnt;
  logic             pscTick;
  logic             atTop;
  logic             stepNow;
  logic [CNT_W-1:0] cntNext;

  assign pscTick = (pscCnt >= pscDiv);
  assign atTop   = (cnt >= reloadVal);
  assign cntNext = atTop ? '0 : cnt + 1'b1;
  assign stepNow = cntCtl.run & pscTick & ~cntCtl.clear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      pscCnt <= '0;
    end else if (cntCtl.clear) begin
      cnt    <= '0;
      pscCnt <= '0;
    end else if (cntCtl.run) begin
      if (pscTick) begin
        pscCnt <= '0;
        cnt    <= cntNext;
      end else begin
        pscCnt <= pscCnt + 1'b1;
      end
    end
  end

  assign updEvt = cntCtl.swUpdate | (stepNow & atTop);
  assign cc1Evt = stepNow & (cntNext == cmpVals[CNT_W-1:0]);

  for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
    assign ocRef[g] = (cnt >= cmpVals[g*CNT_W +: CNT_W]);
  end

endmodule

// File: rtl/trig_out_mux.sv
module trig_out_mux
  import trig_out_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         masterMode,
  input  trg_src_t           trgSrc,
  input  logic               updEvt,
  input  logic               cc1Evt,
  input  logic [NUM_REF-1:0] ocRef,
  output logic               trgo
);

  master_mode_e mm;
  logic         srcSel;

  assign mm = master_mode_e'(masterMode);

  always_comb begin
    unique case (mm)
      MM_SWRESET: srcSel = trgSrc.resetMark;
      MM_ENABLE:  srcSel = trgSrc.enLevel;
      MM_UPDATE:  srcSel = updEvt;
      MM_CC1PUL:  srcSel = cc1Evt;
      default:    srcSel = ocRef[masterMode[1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) trgo <= 1'b0;
    else       trgo <= srcSel;
  end

endmodule

// File: rtl/trig_out_sel.sv
module trig_out_sel
  import trig_out_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PSC_W = 8,
  localparam int CMP_W = NUM_REF * CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ugStrobe,
  input  logic             cntEnBit,
  input  logic             trigIn,
  input  logic [1:0]       slaveMode,
  input  logic             msmSync,
  input  logic [2:0]       masterMode,
  input  logic [PSC_W-1:0] pscDiv,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CMP_W-1:0] cmpVals,
  output logic [CNT_W-1:0] cntOut,
  output logic             trgo
);

  cnt_ctrl_t          cntCtl;
  trg_src_t           trgSrc;
  logic               updEvt;
  logic               cc1Evt;
  logic [NUM_REF-1:0] ocRef;

  trig_out_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ugStrobe(ugStrobe), .cntEnBit(cntEnBit),
    .trigIn(trigIn), .slaveMode(slaveMode), .msmSync(msmSync),
    .cntCtl(cntCtl), .trgSrc(trgSrc)
  );

  trig_out_datapath #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dp (
    .clk(clk), .rstN(rstN), .cntCtl(cntCtl), .pscDiv(pscDiv),
    .reloadVal(reloadVal), .cmpVals(cmpVals), .cnt(cntOut),
    .updEvt(updEvt), .cc1Evt(cc1Evt), .ocRef(ocRef)
  );

  trig_out_mux u_mux (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .trgSrc(trgSrc),
    .updEvt(updEvt), .cc1Evt(cc1Evt), .ocRef(ocRef), .trgo(trgo)
  );

endmodule

// File: rtl/trig_out_sel_chk.sv
module trig_out_sel_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             ugStrobe,
  input logic             trigIn,
  input logic [1:0]       slaveMode,
  input logic             msmSync,
  input logic [2:0]       masterMode,
  input logic [CNT_W-1:0] reloadVal,
  input logic [CNT_W-1:0] cmpFirst,
  input logic [CNT_W-1:0] cntOut,
  input logic             trgo
);

  // R3: software strobe leaves the count at zero
  p_ug_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    ugStrobe |=> (cntOut == '0));

  // R2: with a steady limit, the count never leaves 0..reloadVal
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(reloadVal) && (cntOut <= reloadVal)) |=> (cntOut <= reloadVal));

  // R4: update source pulses after a software strobe
  p_update_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode == 3'b010 && ugStrobe) |=> trgo);

  // R9: channel-1 reference shows one cycle later
  p_ref_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode == 3'b100) |=> (trgo == $past(cntOut >= cmpFirst)));

  // R6: gated mode with the trigger low holds the count
  p_gated_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (slaveMode == 2'b01 && !msmSync && !trigIn && !ugStrobe) |=> $stable(cntOut));

endmodule

bind trig_out_sel trig_out_sel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .ugStrobe(ugStrobe), .trigIn(trigIn),
  .slaveMode(slaveMode), .msmSync(msmSync), .masterMode(masterMode),
  .reloadVal(reloadVal), .cmpFirst(cmpVals[CNT_W-1:0]),
  .cntOut(cntOut), .trgo(trgo)
);

// File: tb/trig_out_sel_bench.sv
module trig_out_sel_bench;

  localparam int CNT_W = 8;
  localparam int PSC_W = 8;

  logic             clk;
  logic             rstN;
  logic             ugStrobe;
  logic             cntEnBit;
  logic             trigIn;
  logic [1:0]       slaveMode;
  logic             msmSync;
  logic [2:0]       masterMode;
  logic [PSC_W-1:0] pscDiv;
  logic [CNT_W-1:0] reloadVal;
  logic [4*CNT_W-1:0] cmpVals;
  logic [CNT_W-1:0] cntOut;
  logic             trgo;

  trig_out_sel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_trig_out_sel (
    .clk(clk), .rstN(rstN), .ugStrobe(ugStrobe), .cntEnBit(cntEnBit),
    .trigIn(trigIn), .slaveMode(slaveMode), .msmSync(msmSync),
    .masterMode(masterMode), .pscDiv(pscDiv), .reloadVal(reloadVal),
    .cmpVals(cmpVals), .cntOut(cntOut), .trgo(trgo)
  );

  typedef struct {
    string req;
    bit    onTrgo;
    int    val;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 0;

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  // expectation for the outputs right after the next rising edge
  task automatic want(string req, bit onTrgo, int v);
    exp_t e;
    e.req = req; e.onTrgo = onTrgo; e.val = v;
    expQ.push_back(e);
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // monitor: pops every item queued for this edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (expQ.size() > 0) begin
        exp_t e;
        int act;
        e = expQ.pop_front();
        act = e.onTrgo ? int'(trgo) : int'(cntOut);
        nChecks++;
        if (act != e.val) begin
          nFails++;
          $display("FAIL %s: %s actual %0d expected %0d", e.req,
                   e.onTrgo ? "trgo" : "cntOut", act, e.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 0; ugStrobe = 0; cntEnBit = 1; trigIn = 0; slaveMode = 2'b00;
    msmSync = 0; masterMode = 3'b010; pscDiv = 1; reloadVal = 3; cmpVals = '0;
    nxt(); nxt();
    want("R1", 0, 0); want("R1", 1, 0);
    nxt();
    rstN = 1;

    // R2 and R4: divide by 2, period of 4 counts
    for (int k = 1; k <= 16; k++) begin
      want("R2", 0, (k / 2) % 4);
      want("R4", 1, (k % 8 == 0) ? 1 : 0);
      nxt();
    end

    // R3 and R11: strobe, then strobe on the wrap edge
    pscDiv = 0; reloadVal = 3; ugStrobe = 1;
    want("R3", 0, 0); want("R4", 1, 1);
    nxt();
    ugStrobe = 0;
    for (int k = 1; k <= 3; k++) begin
      want("R2", 0, k); want("R4", 1, 0);
      nxt();
    end
    ugStrobe = 1;
    want("R11", 0, 0); want("R11", 1, 1);
    nxt();
    ugStrobe = 0;
    want("R11", 0, 1); want("R11", 1, 0);
    nxt();

    // R3: strobe in mid-prescale restarts the prescaler
    pscDiv = 2; ugStrobe = 1;
    want("R3", 0, 0);
    nxt();
    ugStrobe = 0;
    want("R3", 0, 0);
    nxt();
    ugStrobe = 1;
    want("R3", 0, 0);
    nxt();
    ugStrobe = 0;
    want("R3", 0, 0);
    nxt();
    want("R3", 0, 0);
    nxt();
    want("R3", 0, 1);
    nxt();

    // R9: compare references of the four channels
    pscDiv = 0; reloadVal = 7;
    cmpVals = {8'd7, 8'd6, 8'd4, 8'd2};
    for (int ch = 0; ch < 4; ch++) begin
      int cv;
      cv = (ch == 0) ? 2 : (ch == 1) ? 4 : (ch == 2) ? 6 : 7;
      masterMode = 3'(4 + ch); ugStrobe = 1;
      nxt();
      ugStrobe = 0;
      for (int k = 1; k <= 9; k++) begin
        want("R9", 1, (((k - 1) % 8) >= cv) ? 1 : 0);
        want("R2", 0, k % 8);
        nxt();
      end
    end

    // R8: channel-1 match pulse
    masterMode = 3'b011; reloadVal = 3; cmpVals = {8'd7, 8'd6, 8'd4, 8'd2};
    ugStrobe = 1;
    want("R8", 1, 0);
    nxt();
    ugStrobe = 0;
    for (int k = 1; k <= 9; k++) begin
      want("R8", 1, (k % 4 == 2) ? 1 : 0);
      nxt();
    end
    cmpVals = {8'd7, 8'd6, 8'd4, 8'd0};
    ugStrobe = 1;
    want("R8", 1, 0);
    nxt();
    ugStrobe = 0;
    for (int k = 1; k <= 9; k++) begin
      want("R8", 1, (k % 4 == 0) ? 1 : 0);
      nxt();
    end

    // R7 and R6: gated by trigger, no sync
    masterMode = 3'b001; reloadVal = 255; slaveMode = 2'b01;
    cntEnBit = 1; trigIn = 0; msmSync = 0; ugStrobe = 1;
    want("R3", 0, 0);
    nxt();
    ugStrobe = 0;
    want("R6", 0, 0); want("R7", 1, 0);
    nxt();
    trigIn = 1;
    want("R7", 0, 1); want("R7", 1, 0);
    nxt();
    want("R7", 0, 2); want("R7", 1, 1);
    nxt();
    want("R7", 0, 3); want("R7", 1, 1);
    nxt();
    trigIn = 0;
    want("R6", 0, 3); want("R7", 1, 1);
    nxt();
    want("R6", 0, 3); want("R7", 1, 0);
    nxt();

    // R7: gated with sync, count and output line up
    msmSync = 1; trigIn = 1;
    want("R7", 0, 3); want("R7", 1, 0);
    nxt();
    want("R7", 0, 4); want("R7", 1, 1);
    nxt();
    trigIn = 0;
    want("R7", 0, 5); want("R7", 1, 1);
    nxt();
    want("R7", 0, 5); want("R7", 1, 0);
    nxt();

    // R7: software enable, free mode
    slaveMode = 2'b00; msmSync = 0; cntEnBit = 0;
    want("R6", 0, 5); want("R7", 1, 0);
    nxt();
    cntEnBit = 1;
    want("R7", 0, 6); want("R7", 1, 1);
    nxt();
    cntEnBit = 0;
    want("R7", 0, 6); want("R7", 1, 0);
    nxt();

    // R5 and R6: restart slave mode, no sync
    masterMode = 3'b000; slaveMode = 2'b10; cntEnBit = 1; ugStrobe = 1;
    want("R5", 0, 0); want("R5", 1, 1);
    nxt();
    ugStrobe = 0;
    for (int k = 1; k <= 3; k++) begin
      want("R6", 0, k); want("R5", 1, 0);
      nxt();
    end
    trigIn = 1;
    want("R6", 0, 0); want("R5", 1, 0);
    nxt();
    want("R6", 0, 1); want("R5", 1, 1);
    nxt();
    want("R6", 0, 2); want("R5", 1, 0);
    nxt();
    trigIn = 0;
    want("R6", 0, 3);
    nxt();
    want("R6", 0, 4);
    nxt();

    // R5: restart with sync, clear and pulse together
    msmSync = 1; trigIn = 1;
    want("R5", 0, 5); want("R5", 1, 0);
    nxt();
    want("R5", 0, 0); want("R5", 1, 1);
    nxt();
    want("R5", 0, 1); want("R5", 1, 0);
    nxt();
    trigIn = 0;
    nxt(); nxt();

    // R10: mode switches appear after the next edge
    slaveMode = 2'b00; msmSync = 0; cntEnBit = 0;
    cmpVals = {8'd7, 8'd6, 8'd1, 8'd0};
    masterMode = 3'b101; ugStrobe = 1;
    nxt();
    ugStrobe = 0;
    want("R10", 1, 0);
    nxt();
    masterMode = 3'b100;
    want("R10", 1, 1);
    nxt();
    masterMode = 3'b101;
    want("R10", 1, 0);
    nxt();
    masterMode = 3'b100;
    want("R10", 1, 1); want("R6", 0, 0);
    nxt();

    nxt(); nxt();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule